// File: doc/BRIEF.md
# Request/Grant Bus Arbiter

This block sits on the processor side of a shared bus. It arbitrates between two external requesters, each connected by a single request/grant line. Every transaction on a line is a sequence of three one-clock pulses. First the requester pulses the line to ask for the bus. When the arbiter hands the bus over, it pulses the same line back as a grant. Later the requester pulses the line once more to give the bus back. The bidirectional line is modelled as a sampled input, a driven output and an output enable.

The arbiter never breaks into a bus cycle that is running. It waits until the bus-busy input shows the current cycle has ended, and only then issues a grant. When more than one request is pending at that moment, line 0 wins. From the grant until the release is seen, the arbiter holds a float indication for the processor's bus drivers and reports which line owns the bus. A request that arrives from the other line during that time is remembered and served after the release.

Top module: `rqgt_arbiter`

## Requirements
- R1: A synchronous active-high reset forces the idle state on the next clock edge and clears all pending requests. While reset is held and after it is released, `rg_out`, `rg_oe`, `bus_float` and `owner_valid` are 0 and `owner_id` is 0. No grant follows unless a new request pulse arrives.
- R2: A one-clock request pulse on `rg_in[i]` with the bus idle and `bus_busy` low produces a grant pulse on `rg_out[i]`. The grant is exactly one clock wide and appears in the cycle after the edge that follows the edge sampling the request.
- R3: No grant is issued at an edge where `bus_busy` is sampled high. A pending request is granted at the first edge where `bus_busy` is low.
- R4: When both lines are pending at the edge where a grant is decided, line 0 is granted. Line 1 stays pending and is granted after line 0 releases.
- R5: `bus_float` is high from the grant cycle through the whole hold phase. It goes low on the edge that samples the owner's release pulse.
- R6: `owner_valid` is high exactly while `bus_float` is high. `owner_id` then gives the owning line number, where line 0 is 0 and line 1 is 1. `owner_id` is 0 while `owner_valid` is low.
- R7: A request pulse from the non-owning line during a grant or hold is kept pending. It causes no grant before the owner's release.
- R8: A pulse on the owner's own line during the grant cycle is ignored: it neither ends the hold nor is counted as a new request. `rg_oe` is one-hot or zero and equals `rg_out` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_busy | input | 1 | High while a processor bus cycle is in progress |
| rg_in | input | NLINES | Sampled level of each request/grant line |
| rg_out | output | NLINES | Grant pulse driven onto each line |
| rg_oe | output | NLINES | Output enable for each line's driver |
| bus_float | output | 1 | Processor bus drivers must float |
| owner_valid | output | 1 | A requester owns the bus |
| owner_id | output | $clog2(NLINES) | Index of the owning line |

## Verification
The bench raises requests while `bus_busy` is high. A design that granted without waiting for the cycle boundary would pulse the line too early. Requests from both lines are placed so that both are pending at the same boundary, and also so that line 1 arrives first and line 0 arrives later but still before the boundary. A design that served requests in arrival order, or that decided priority at arrival, would grant line 1 first. A request from the other line is injected mid-hold, and a stray pulse is placed on the owner's line during the grant cycle. These catch a design that drops pending work, grants twice, or releases on its own driven pulse. A reset in the middle of a hold checks that no stale grant or float survives.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_HOLD  = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       busy_owned;
    } arb_status_t;

    function automatic logic is_owned(input arb_state_e s);
        return (s == ARB_GRANT) || (s == ARB_HOLD);
    endfunction

endpackage

// File: rtl/rqgt_pending.sv
module rqgt_pending #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] set_req,
    input  logic [NLINES-1:0] clr_req,
    output logic [NLINES-1:0] pend
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (clr_req[i]) begin
                pend[i] <= 1'b0;
            end else if (set_req[i]) begin
                pend[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rqgt_priority.sv
module rqgt_priority #(
    parameter int NLINES = 2,
    localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] pick_onehot,
    output logic [IDW-1:0]    pick_id,
    output logic              pick_any
);
    logic [NLINES:0] lower;

    assign lower[0] = 1'b0;
    for (genvar i = 0; i < NLINES; i++) begin : g_chain
        assign lower[i+1]     = lower[i] | pend[i];
        assign pick_onehot[i] = pend[i] & ~lower[i];
    end
    assign pick_any = lower[NLINES];

    always_comb begin
        pick_id = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (pend[i]) pick_id = IDW'(i);
        end
    end
endmodule

// File: rtl/rqgt_fsm.sv
module rqgt_fsm
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2,
    localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_busy,
    input  logic           pick_any,
    input  logic [IDW-1:0] pick_id,
    input  logic           release_seen,
    output arb_state_e     state,
    output logic [IDW-1:0] owner,
    output logic           take
);
    assign take = (state == ARB_IDLE) && pick_any && !bus_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            owner <= '0;
        end else begin
            unique case (state)
                ARB_IDLE: begin
                    if (take) begin
                        state <= ARB_GRANT;
                        owner <= pick_id;
                    end
                end
                ARB_GRANT: state <= ARB_HOLD;
                ARB_HOLD: begin
                    if (release_seen) begin
                        state <= ARB_IDLE;
                        owner <= '0;
                    end
                end
                default: begin
                    state <= ARB_IDLE;
                    owner <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
    import rqgt_pkg::*;
#(
    parameter int NLINES = 2,
    localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_busy,
    input  logic [NLINES-1:0] rg_in,
    output logic [NLINES-1:0] rg_out,
    output logic [NLINES-1:0] rg_oe,
    output logic              bus_float,
    output logic              owner_valid,
    output logic [IDW-1:0]    owner_id
);
    arb_state_e        state;
    arb_status_t       status;
    logic [IDW-1:0]    owner;
    logic [NLINES-1:0] own_mask;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] pick_onehot;
    logic [NLINES-1:0] set_req;
    logic [NLINES-1:0] clr_req;
    logic [IDW-1:0]    pick_id;
    logic              pick_any;
    logic              take;
    logic              release_seen;

    assign status.state      = state;
    assign status.busy_owned = is_owned(state);

    for (genvar i = 0; i < NLINES; i++) begin : g_mask
        assign own_mask[i] = status.busy_owned && (owner == IDW'(i));
    end

    // Owner's line is never a request while it holds the bus
    assign set_req      = rg_in & ~own_mask;
    assign clr_req      = take ? pick_onehot : '0;
    assign release_seen = (status.state == ARB_HOLD) && |(rg_in & own_mask);

    rqgt_pending #(.NLINES(NLINES)) u_pending (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .clr_req (clr_req),
        .pend    (pend)
    );

    rqgt_priority #(.NLINES(NLINES)) u_priority (
        .pend        (pend),
        .pick_onehot (pick_onehot),
        .pick_id     (pick_id),
        .pick_any    (pick_any)
    );

    rqgt_fsm #(.NLINES(NLINES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .bus_busy     (bus_busy),
        .pick_any     (pick_any),
        .pick_id      (pick_id),
        .release_seen (release_seen),
        .state        (state),
        .owner        (owner),
        .take         (take)
    );

    assign rg_out      = (status.state == ARB_GRANT) ? own_mask : '0;
    assign rg_oe       = (status.state == ARB_GRANT) ? own_mask : '0;
    assign bus_float   = status.busy_owned;
    assign owner_valid = status.busy_owned;
    assign owner_id    = owner;
endmodule

// File: rtl/rqgt_arbiter_chk.sv
module rqgt_arbiter_chk #(
    parameter int NLINES = 2,
    localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_busy,
    input logic [NLINES-1:0] rg_in,
    input logic [NLINES-1:0] rg_out,
    input logic [NLINES-1:0] rg_oe,
    input logic              bus_float,
    input logic              owner_valid,
    input logic [IDW-1:0]    owner_id
);
    a_r2_grant_one_clock: assert property (@(posedge clk) disable iff (rst)
        (|rg_out) |=> !(|rg_out));

    a_r3_no_grant_when_busy: assert property (@(posedge clk) disable iff (rst)
        (|rg_out) |-> !$past(bus_busy));

    a_r5_float_during_grant: assert property (@(posedge clk) disable iff (rst)
        (|rg_out) |-> bus_float);

    a_r5_float_held: assert property (@(posedge clk) disable iff (rst)
        (bus_float && !rg_in[owner_id]) |=> bus_float);

    a_r5_float_drops_on_release: assert property (@(posedge clk) disable iff (rst)
        (owner_valid && !(|rg_out) && rg_in[owner_id]) |=> !bus_float);

    a_r6_owner_starts_with_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(owner_valid) |-> (|rg_out));

    a_r6_id_zero_when_free: assert property (@(posedge clk) disable iff (rst)
        !owner_valid |-> (owner_id == '0));

    a_r8_oe_matches_out: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rg_oe) && (rg_oe == rg_out));
endmodule

bind rqgt_arbiter rqgt_arbiter_chk #(.NLINES(NLINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_busy    (bus_busy),
    .rg_in       (rg_in),
    .rg_out      (rg_out),
    .rg_oe       (rg_oe),
    .bus_float   (bus_float),
    .owner_valid (owner_valid),
    .owner_id    (owner_id)
);

// File: tb/rqgt_arbiter_test.sv
module rqgt_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_busy = 1'b0;
    logic [1:0] rg_in = 2'b00;
    logic [1:0] rg_out;
    logic [1:0] rg_oe;
    logic       bus_float;
    logic       owner_valid;
    logic [0:0] owner_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rqgt_arbiter #(.NLINES(2)) uut (
        .clk         (clk),
        .rst         (rst),
        .bus_busy    (bus_busy),
        .rg_in       (rg_in),
        .rg_out      (rg_out),
        .rg_oe       (rg_oe),
        .bus_float   (bus_float),
        .owner_valid (owner_valid),
        .owner_id    (owner_id)
    );

    // {req[1:0], busy, exp_out[1:0], exp_float, exp_valid, exp_id}
    localparam int NROWS = 27;
    localparam logic [7:0] VEC [NROWS] = '{
        8'b00000000, // idle
        8'b01000000, // R2 request line 0
        8'b00001110, // R2 grant line 0
        8'b00000110, // R5 hold
        8'b10000110, // R7 line 1 asks mid-hold
        8'b01000000, // R5 release line 0
        8'b00100000, // R3 busy blocks pending line 1
        8'b00100000, // R3 still busy
        8'b00010111, // R3 grant line 1 at boundary
        8'b00000111, // R6 hold by line 1
        8'b10000000, // R5 release line 1
        8'b10100000, // R4 line 1 first, busy
        8'b01100000, // R4 line 0 later, busy
        8'b00001110, // R4 line 0 wins
        8'b00000110, // hold
        8'b01000000, // release
        8'b00010111, // R4 line 1 served next
        8'b00000111, // hold
        8'b10000000, // release
        8'b11000000, // R4 both at once
        8'b00001110, // R4 line 0 wins
        8'b00000110, // hold
        8'b01000000, // release
        8'b00010111, // line 1 granted
        8'b00000111, // hold
        8'b10000000, // release
        8'b00000000  // idle
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input logic [1:0] eo, input logic ef,
                              input logic ev, input logic ei);
        check(rg_out == eo, tag, "rg_out", int'(rg_out), int'(eo));
        check(rg_oe == eo, tag, "rg_oe", int'(rg_oe), int'(eo));
        check(bus_float == ef, tag, "bus_float", int'(bus_float), int'(ef));
        check(owner_valid == ev, tag, "owner_valid", int'(owner_valid), int'(ev));
        check(owner_id == ei, tag, "owner_id", int'(owner_id), int'(ei));
    endtask

    task automatic step(input logic [1:0] req, input logic busy);
        rg_in    = req;
        bus_busy = busy;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R1 reset held", 2'b00, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NROWS; k++) begin
            step(VEC[k][7:6], VEC[k][5]);
            check_outs($sformatf("table(R2,R3,R4,R5,R6,R7) row %0d", k),
                       VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0]);
        end

        // R1: reset in the middle of a hold, with line 1 pending
        step(2'b01, 1'b0);
        step(2'b00, 1'b0);
        check_outs("R1 pre-reset grant", 2'b01, 1'b1, 1'b1, 1'b0);
        step(2'b10, 1'b0);
        rst = 1'b1;
        step(2'b00, 1'b0);
        check_outs("R1 reset mid-hold", 2'b00, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(2'b00, 1'b0);
            check_outs("R1 pending cleared", 2'b00, 1'b0, 1'b0, 1'b0);
        end

        // R8: stray pulse on owner's line during its grant cycle
        step(2'b01, 1'b0);
        step(2'b00, 1'b0);
        check_outs("R8 grant", 2'b01, 1'b1, 1'b1, 1'b0);
        step(2'b01, 1'b0);
        check_outs("R8 stray pulse ignored", 2'b00, 1'b1, 1'b1, 1'b0);
        step(2'b01, 1'b0);
        check_outs("R8 real release", 2'b00, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin
            step(2'b00, 1'b0);
            check_outs("R8 no re-grant", 2'b00, 1'b0, 1'b0, 1'b0);
        end

        // R2/R3: request whose boundary comes the same cycle busy ends
        step(2'b10, 1'b1);
        step(2'b00, 1'b1);
        check_outs("R3 held while busy", 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0);
        check_outs("R2 grant line 1", 2'b10, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b0);
        check_outs("R2 single clock grant", 2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b10, 1'b0);
        check_outs("R5 release", 2'b00, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule